// File: doc/BRIEF.md
# Receive Character Queue with Status Reporting and Interrupt Logic

This block sits between a serial receiver's deserializer and the host. It holds up to 16 received 8-bit characters. Each character carries three status flags: framing error, parity error and break. The oldest character is always presented at the read side. The host pops it with a one-cycle read strobe.

The block reports error status in one of two ways. In per-character mode it shows only the flags of the oldest character. In block mode it shows a sticky OR that collects every character to reach the read side since the host last issued the clear-error command.

A four-bit interrupt status vector combines four sources: a programmable fill-level condition, an error at the output, a sticky overrun flag and a break at the output. The host can read this vector raw or gated by a mask. The interrupt line fires on any masked source.

The host controls a ready-to-send output with set and clear commands. Optionally the block clears it by itself when the receiver reports a start bit while the queue is nearly full. It sets it again once the queue has drained.

Top module: `rx_char_queue`

## Requirements
- R1: After a synchronous active-low reset, the fill count is 0, `rd_valid` is 0, `rts` is 0, `overrun` is 0 and `isr` reads 0.
- R2: The queue holds up to 16 entries in arrival order. `rd_data` shows the oldest entry whenever `rd_valid` is 1, and `fill_level` shows the entry count one cycle after each accepted write or read.
- R3: `isr[0]` (fill-level source) is 1 when the fill meets the level chosen by `cfg_irq_level`. The codes are 00 for at least 1 entry, 01 for at least 8, 10 for at least 12 and 11 for exactly 16.
- R4: A write while the queue is full and no read is accepted in the same cycle is discarded. It sets the sticky `overrun` flag, which only the clear-error command clears.
- R5: A read strobe while the queue is empty has no effect on the count or on later data.
- R6: With `cfg_block_err` = 0, `rd_status` bit 0 (framing), bit 1 (parity) and bit 2 (break) equal those of the oldest entry, and are 0 when the queue is empty.
- R7: With `cfg_block_err` = 1, each `rd_status` bit is the OR of that bit over every entry that has reached the read side since the last clear-error command.
- R8: `err_clear` clears the block-mode accumulation and the overrun flag at the next clock edge. In the cycle it is high, `rd_status` already excludes the accumulated history and shows only the current oldest entry.
- R9: The raw status vector has bit 0 = fill level, bit 1 = any error flag in `rd_status`, bit 2 = overrun and bit 3 = break flag in `rd_status`. With `cfg_isr_masked` = 1, `isr` is raw AND `irq_mask`; with 0, `isr` is raw. `irq` is the OR of raw AND `irq_mask` in both modes.
- R10: `rts_set` makes `rts` 1 at the next edge and `rts_clr` makes it 0 at the next edge. If both are high, `rts_clr` wins.
- R11: With `cfg_auto_rts` = 1, a `start_bit` pulse while the fill is 15 or more clears `rts` at the next edge. With a fill of 14, or with auto control off, the pulse has no effect.
- R12: After an automatic clear, `rts` returns to 1 at the edge after the fill is seen below 12. It stays 0 while the fill is 12 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Received character |
| wr_status | input | 3 | Received flags: bit0 framing, bit1 parity, bit2 break |
| start_bit | input | 1 | Receiver saw a valid start bit |
| rd_en | input | 1 | Host read (pop) strobe |
| err_clear | input | 1 | Clear-error command |
| rts_set | input | 1 | Command: assert ready-to-send |
| rts_clr | input | 1 | Command: negate ready-to-send |
| cfg_irq_level | input | 2 | Fill-level interrupt selection |
| cfg_block_err | input | 1 | 1 = block error mode, 0 = per-character |
| cfg_auto_rts | input | 1 | Enable automatic ready-to-send control |
| cfg_isr_masked | input | 1 | 1 = status read masked |
| irq_mask | input | 4 | Interrupt mask |
| rd_data | output | 8 | Oldest character |
| rd_status | output | 3 | Reported error flags |
| rd_valid | output | 1 | Queue not empty |
| fill_level | output | 5 | Entry count |
| overrun | output | 1 | Sticky overrun flag |
| isr | output | 4 | Interrupt status vector |
| irq | output | 1 | Interrupt request |
| rts | output | 1 | Ready-to-send, active high |

## Verification
The properties assume the configuration inputs only change between clock edges, and that the set and clear commands are single-cycle pulses. Any strobe may be high in any cycle. The stimulus drives every input on the falling edge. It changes configuration only when no write or read is pending, and it pulses each command for exactly one cycle. It fills and drains the queue through every count from 0 to 16, and sweeps every mask value in both read modes.

// File: rtl/rxq_pkg.sv
// Shared widths, field positions and types for the receive character queue.
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int ST_W   = 3;
    localparam int ST_FE  = 0;
    localparam int ST_PE  = 1;
    localparam int ST_BRK = 2;

    localparam int ISR_W     = 4;
    localparam int ISR_LEVEL = 0;
    localparam int ISR_ERR   = 1;
    localparam int ISR_OVR   = 2;
    localparam int ISR_BRK   = 3;

    typedef struct packed {
        logic [ST_W-1:0]   st;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        LVL_READY = 2'b00,
        LVL_HALF  = 2'b01,
        LVL_3Q    = 2'b10,
        LVL_FULL  = 2'b11
    } rxq_lvl_e;
endpackage

// File: rtl/rxq_storage.sv
// Circular entry store with count.
// Assumes: the caller may strobe push and pop in any cycle. A push is taken
// when there is room or a pop is taken in the same cycle. A pop on empty is
// ignored.
module rxq_storage
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rxq_entry_t       din,
    input  logic             pop,
    output rxq_entry_t       head,
    output logic             empty,
    output logic             full,
    output logic             push_drop,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Work out which requests are honoured this cycle.
    always_comb begin
        empty     = (count == '0);
        full      = (count == CNT_MAX);
        pop_ok    = pop && !empty;
        push_ok   = push && (!full || pop_ok);
        push_drop = push && !push_ok;
        head      = mem[rd_ptr];
    end

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_err_track.sv
// Error status reporting in per-character or sticky block mode, plus overrun.
// Assumes: head_st is meaningful only while head_valid is 1. A clear request
// hides the accumulated history in its own cycle and clears it at the edge.
module rxq_err_track
    import rxq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            block_mode,
    input  logic            err_clear,
    input  logic            head_valid,
    input  logic [ST_W-1:0] head_st,
    input  logic            drop,
    output logic [ST_W-1:0] rep_st,
    output logic            ovr
);
    genvar g;
    generate
        for (g = 0; g < ST_W; g++) begin : g_flag
            logic acc;
            logic view;

            assign view = head_valid & head_st[g];

            // Collect this flag over every entry that reaches the read side.
            always_ff @(posedge clk) begin
                if (!rst_n)           acc <= 1'b0;
                else if (err_clear)   acc <= 1'b0;
                else if (block_mode)  acc <= acc | view;
            end

            assign rep_st[g] = block_mode ? ((acc & ~err_clear) | view) : view;
        end
    endgenerate

    // Sticky overrun: a dropped write sets it, a clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr <= 1'b0;
        else if (drop)      ovr <= 1'b1;
        else if (err_clear) ovr <= 1'b0;
    end
endmodule

// File: rtl/rxq_irq.sv
// Fill-level detection and interrupt status vector with mask read mode.
// Assumes: fill never exceeds DEPTH.
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [1:0]       lvl_sel,
    input  logic [ST_W-1:0]  rep_st,
    input  logic             ovr,
    input  logic             masked_mode,
    input  logic [ISR_W-1:0] mask,
    output logic [ISR_W-1:0] isr,
    output logic             irq
);
    localparam logic [CNT_W-1:0] TH_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] TH_3Q   = CNT_W'((DEPTH * 3) / 4);
    localparam logic [CNT_W-1:0] TH_FULL = CNT_W'(DEPTH);

    logic             lvl_hit;
    logic [ISR_W-1:0] raw;

    // Compare the fill against the selected level.
    always_comb begin
        case (rxq_lvl_e'(lvl_sel))
            LVL_READY: lvl_hit = (fill != '0);
            LVL_HALF:  lvl_hit = (fill >= TH_HALF);
            LVL_3Q:    lvl_hit = (fill >= TH_3Q);
            default:   lvl_hit = (fill == TH_FULL);
        endcase
    end

    // Build the raw vector and apply the read mode.
    always_comb begin
        raw            = '0;
        raw[ISR_LEVEL] = lvl_hit;
        raw[ISR_ERR]   = |rep_st;
        raw[ISR_OVR]   = ovr;
        raw[ISR_BRK]   = rep_st[ST_BRK];
        isr            = masked_mode ? (raw & mask) : raw;
        irq            = |(raw & mask);
    end
endmodule

// File: rtl/rxq_rts_ctl.sv
// Ready-to-send output: host commands plus automatic overrun protection.
// Assumes: start_bit is a one-cycle pulse from the receiver. Host commands
// take priority over automatic action, and clear beats set.
module rxq_rts_ctl #(
    parameter int CNT_W = 5,
    parameter int HI    = 15,
    parameter int LO    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_set,
    input  logic             cmd_clr,
    input  logic             auto_en,
    input  logic             start_bit,
    input  logic [CNT_W-1:0] fill,
    output logic             rts
);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);

    logic auto_held;

    // Update the output from commands, then the automatic drop and restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts       <= 1'b0;
            auto_held <= 1'b0;
        end else if (cmd_clr) begin
            rts       <= 1'b0;
            auto_held <= 1'b0;
        end else if (cmd_set) begin
            rts       <= 1'b1;
            auto_held <= 1'b0;
        end else if (auto_en && start_bit && rts && (fill >= HI_C)) begin
            rts       <= 1'b0;
            auto_held <= 1'b1;
        end else if (auto_held && (fill < LO_C)) begin
            rts       <= 1'b1;
            auto_held <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_char_queue.sv
// Top: receive character queue with error reporting, interrupt status and
// ready-to-send control. Assumes: configuration inputs change only between
// edges. All strobes are active high.
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RTS_HI  = DEPTH - 1,
    parameter int RTS_LO  = (DEPTH * 3) / 4,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [ST_W-1:0]   wr_status,
    input  logic              start_bit,
    input  logic              rd_en,
    input  logic              err_clear,
    input  logic              rts_set,
    input  logic              rts_clr,
    input  logic [1:0]        cfg_irq_level,
    input  logic              cfg_block_err,
    input  logic              cfg_auto_rts,
    input  logic              cfg_isr_masked,
    input  logic [ISR_W-1:0]  irq_mask,
    output logic [CHAR_W-1:0] rd_data,
    output logic [ST_W-1:0]   rd_status,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  fill_level,
    output logic              overrun,
    output logic [ISR_W-1:0]  isr,
    output logic              irq,
    output logic              rts
);
    rxq_entry_t din;
    rxq_entry_t head;
    logic       empty;
    logic       full;
    logic       drop;

    // Pack the incoming entry.
    always_comb begin
        din.data = wr_data;
        din.st   = wr_status;
    end

    rxq_storage #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .din       (din),
        .pop       (rd_en),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .push_drop (drop),
        .count     (fill_level)
    );

    assign rd_valid = !empty;
    assign rd_data  = head.data;

    rxq_err_track u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_mode (cfg_block_err),
        .err_clear  (err_clear),
        .head_valid (rd_valid),
        .head_st    (head.st),
        .drop       (drop),
        .rep_st     (rd_status),
        .ovr        (overrun)
    );

    rxq_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
        .fill        (fill_level),
        .lvl_sel     (cfg_irq_level),
        .rep_st      (rd_status),
        .ovr         (overrun),
        .masked_mode (cfg_isr_masked),
        .mask        (irq_mask),
        .isr         (isr),
        .irq         (irq)
    );

    rxq_rts_ctl #(.CNT_W(CNT_W), .HI(RTS_HI), .LO(RTS_LO)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_set   (rts_set),
        .cmd_clr   (rts_clr),
        .auto_en   (cfg_auto_rts),
        .start_bit (start_bit),
        .fill      (fill_level),
        .rts       (rts)
    );
endmodule

// File: rtl/rx_char_queue_chk.sv
// Checker for rx_char_queue, attached by bind. Observes ports only.
module rx_char_queue_chk
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RTS_HI = DEPTH - 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             start_bit,
    input logic             err_clear,
    input logic             rts_set,
    input logic             rts_clr,
    input logic             cfg_block_err,
    input logic             cfg_auto_rts,
    input logic             cfg_isr_masked,
    input logic [ISR_W-1:0] irq_mask,
    input logic [ST_W-1:0]  rd_status,
    input logic             rd_valid,
    input logic [CNT_W-1:0] fill_level,
    input logic             overrun,
    input logic [ISR_W-1:0] isr,
    input logic             rts
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HI_C   = CNT_W'(RTS_HI);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL_C);

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FULL_C && wr_en && !rd_en) |=> (fill_level == FULL_C && overrun));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_en && !wr_en) |=> (fill_level == '0));

    assert_char_mode_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_block_err && !rd_valid) |-> (rd_status == '0));

    assert_block_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_block_err && !err_clear && rd_status[ST_FE]) |=>
        (!cfg_block_err || err_clear || rd_status[ST_FE]));

    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !wr_en) |=> !overrun);

    assert_masked_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_isr_masked |-> ((isr & ~irq_mask) == '0));

    assert_cmd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rts_clr |=> !rts);

    assert_cmd_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_set && !rts_clr) |=> rts);

    assert_auto_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && start_bit && fill_level >= HI_C && !rts_set) |=> !rts);
endmodule

bind rx_char_queue rx_char_queue_chk #(.DEPTH(DEPTH), .RTS_HI(RTS_HI), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .start_bit      (start_bit),
    .err_clear      (err_clear),
    .rts_set        (rts_set),
    .rts_clr        (rts_clr),
    .cfg_block_err  (cfg_block_err),
    .cfg_auto_rts   (cfg_auto_rts),
    .cfg_isr_masked (cfg_isr_masked),
    .irq_mask       (irq_mask),
    .rd_status      (rd_status),
    .rd_valid       (rd_valid),
    .fill_level     (fill_level),
    .overrun        (overrun),
    .isr            (isr),
    .rts            (rts)
);

// File: tb/rx_char_queue_tb.sv
// Self-checking bench: sweeps fill counts, level codes, masks and modes.
module rx_char_queue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_status = '0;
    logic       start_bit = 1'b0;
    logic       rd_en = 1'b0;
    logic       err_clear = 1'b0;
    logic       rts_set = 1'b0;
    logic       rts_clr = 1'b0;
    logic [1:0] cfg_irq_level = '0;
    logic       cfg_block_err = 1'b0;
    logic       cfg_auto_rts = 1'b0;
    logic       cfg_isr_masked = 1'b0;
    logic [3:0] irq_mask = '0;
    logic [7:0] rd_data;
    logic [2:0] rd_status;
    logic       rd_valid;
    logic [4:0] fill_level;
    logic       overrun;
    logic [3:0] isr;
    logic       irq;
    logic       rts;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_char_queue u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_status(wr_status), .start_bit(start_bit), .rd_en(rd_en),
        .err_clear(err_clear), .rts_set(rts_set), .rts_clr(rts_clr),
        .cfg_irq_level(cfg_irq_level), .cfg_block_err(cfg_block_err),
        .cfg_auto_rts(cfg_auto_rts), .cfg_isr_masked(cfg_isr_masked),
        .irq_mask(irq_mask), .rd_data(rd_data), .rd_status(rd_status),
        .rd_valid(rd_valid), .fill_level(fill_level), .overrun(overrun),
        .isr(isr), .irq(irq), .rts(rts)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] s);
        wr_en = 1'b1; wr_data = d; wr_status = s;
        @(negedge clk);
        wr_en = 1'b0; wr_status = '0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    function automatic bit level_exp(input int lvl, input int f);
        case (lvl)
            0:       return f >= 1;
            1:       return f >= 8;
            2:       return f >= 12;
            default: return f == 16;
        endcase
    endfunction

    function automatic logic [2:0] blk_pat(input int i);
        return (i == 1) ? 3'd1 : (i == 3) ? 3'd2 : (i == 6) ? 3'd4 : 3'd0;
    endfunction

    initial begin
        logic [2:0] acc;
        logic [3:0] raw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "fill", int'(fill_level), 0);
        check("R1", "rd_valid", int'(rd_valid), 0);
        check("R1", "rts", int'(rts), 0);
        check("R1", "isr", int'(isr), 0);
        check("R1", "overrun", int'(overrun), 0);

        // R2 and R3: fill from 0 to 16, all level codes at each count
        for (int k = 0; k <= 16; k++) begin
            check("R2", "fill while filling", int'(fill_level), k);
            for (int lvl = 0; lvl < 4; lvl++) begin
                cfg_irq_level = 2'(lvl);
                #1;
                check("R3", "level flag", int'(isr[0]), int'(level_exp(lvl, k)));
            end
            cfg_irq_level = 2'd0;
            if (k < 16) push(8'(k * 7 + 1), 3'd0);
        end

        // R4: write into a full queue is dropped
        push(8'hEE, 3'd0);
        check("R4", "fill after drop", int'(fill_level), 16);
        check("R4", "overrun set", int'(overrun), 1);
        check("R4", "isr overrun bit", int'(isr[2]), 1);

        // R2: drain in order
        for (int i = 0; i < 16; i++) begin
            check("R2", "order", int'(rd_data), (i * 7 + 1) & 8'hFF);
            pop();
            check("R2", "fill while draining", int'(fill_level), 15 - i);
        end
        check("R4", "overrun sticky", int'(overrun), 1);

        // R5: read on empty has no effect
        pop();
        check("R5", "fill after empty read", int'(fill_level), 0);
        check("R5", "valid after empty read", int'(rd_valid), 0);
        push(8'h5A, 3'd0);
        check("R5", "data after empty read", int'(rd_data), 8'h5A);
        check("R5", "fill after push", int'(fill_level), 1);
        pop();

        // R8: clear-error command clears overrun
        pulse_clear();
        check("R8", "overrun cleared", int'(overrun), 0);

        // R6: per-character status
        for (int i = 0; i < 8; i++) push(8'(i), 3'(i));
        for (int i = 0; i < 8; i++) begin
            check("R6", "status", int'(rd_status), i);
            check("R9", "isr err bit", int'(isr[1]), int'(i != 0));
            check("R9", "isr brk bit", int'(isr[3]), (i >> 2) & 1);
            pop();
        end
        check("R6", "status when empty", int'(rd_status), 0);

        // R7: block mode accumulation
        cfg_block_err = 1'b1;
        pulse_clear();
        acc = '0;
        for (int i = 0; i < 8; i++) push(8'(i), blk_pat(i));
        for (int i = 0; i < 8; i++) begin
            check("R7", "accumulated", int'(rd_status), int'(acc | blk_pat(i)));
            acc = acc | blk_pat(i);
            pop();
        end
        check("R7", "held when empty", int'(rd_status), 7);

        // R8: clear hides history in its own cycle
        err_clear = 1'b1;
        #1;
        check("R8", "same-cycle clear", int'(rd_status), 0);
        @(negedge clk);
        err_clear = 1'b0;
        check("R8", "after clear", int'(rd_status), 0);
        push(8'h11, 3'd2);
        push(8'h22, 3'd0);
        check("R7", "head flag", int'(rd_status), 2);
        pop();
        check("R7", "kept after pop", int'(rd_status), 2);
        err_clear = 1'b1;
        #1;
        check("R8", "clear with head", int'(rd_status), 0);
        @(negedge clk);
        err_clear = 1'b0;
        pop();
        cfg_block_err = 1'b0;

        // R9: every mask in both read modes; raw = 4'b1011
        push(8'h33, 3'd4);
        raw = 4'b1011;
        for (int m = 0; m < 16; m++) begin
            for (int md = 0; md < 2; md++) begin
                irq_mask = 4'(m);
                cfg_isr_masked = md[0];
                #1;
                check("R9", "isr", int'(isr), md ? int'(raw & 4'(m)) : int'(raw));
                check("R9", "irq", int'(irq), int'(|(raw & 4'(m))));
            end
        end
        cfg_isr_masked = 1'b0;
        irq_mask = '0;

        // R10: host commands
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        check("R10", "set", int'(rts), 1);
        rts_clr = 1'b1; @(negedge clk); rts_clr = 1'b0;
        check("R10", "clear", int'(rts), 0);
        rts_set = 1'b1; rts_clr = 1'b1; @(negedge clk); rts_set = 1'b0; rts_clr = 1'b0;
        check("R10", "clear wins", int'(rts), 0);
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        check("R10", "set again", int'(rts), 1);

        // R11: automatic clear threshold (fill now 1)
        for (int i = 1; i < 14; i++) push(8'(i), 3'd0);
        cfg_auto_rts = 1'b1;
        start_bit = 1'b1; @(negedge clk); start_bit = 1'b0;
        check("R11", "no drop at 14", int'(rts), 1);
        push(8'hF0, 3'd0);
        cfg_auto_rts = 1'b0;
        start_bit = 1'b1; @(negedge clk); start_bit = 1'b0;
        check("R11", "no drop when disabled", int'(rts), 1);
        cfg_auto_rts = 1'b1;
        start_bit = 1'b1; @(negedge clk); start_bit = 1'b0;
        check("R11", "drop at 15", int'(rts), 0);

        // R12: restore once below 12
        for (int f = 15; f > 12; f--) begin
            pop();
            @(negedge clk);
            check("R12", "held while >= 12", int'(rts), 0);
        end
        pop();
        check("R12", "fill 11", int'(fill_level), 11);
        check("R12", "not yet restored", int'(rts), 0);
        @(negedge clk);
        check("R12", "restored", int'(rts), 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule